// File: doc/BRIEF.md
# Core Clock Frequency Switch Controller

This block moves a processor core clock between a 26 MHz crystal source and three PLL-derived frequencies (370, 540 and 720 MHz). A client asks for a frequency by presenting its value in MHz. The controller then walks a fixed series of steps. Each step either asks a PLL power sequencer to power the PLL up or down, commits one of two clock-mux selects, or writes the PLL frequency word. Every step is a request/acknowledge handshake, and the next step starts only after the acknowledge. The order of the steps depends on the direction of the change. Going onto the PLL, it powers the PLL first and writes the frequency word last. Going back to the crystal, it releases the muxes first and removes PLL power last.

The clock tree state is not known after a reset. For that case an initialisation command drives the block through a forced move to the lowest setting and then a forced move to the highest setting. The block reports the index of the frequency it currently runs at, and a busy flag while a change is under way.

Top module: `clkfreq_switch`

## Requirements
- R1: After reset, cur_idx is 0 (26 MHz), busy is low and no request line (pwr_req, sel_req, word_req) is high.
- R2: Request values map to indices as 26→0, 370→1, 540→2 and 720→3. Index 0 runs from the crystal and indices 1 to 3 run from the PLL.
- R3: A move to a PLL index runs four handshakes in this order: PLL power-up (pwr_req with pwr_on=1), select sel_id=0 committed to 8, select sel_id=1 committed to 7, then the frequency word.
- R4: The frequency word is 0x831C7628 for index 1, 0x8214C4ED for index 2 and 0x821BB13C for index 3.
- R5: A move to index 0 runs three handshakes in this order: select sel_id=1 committed to 0, select sel_id=0 committed to 0, then PLL power-down (pwr_req with pwr_on=0).
- R6: A request for the index already in use starts no handshake and leaves busy low.
- R7: A request value that matches no table entry starts no handshake and leaves busy low.
- R8: At most one request line is high at a time. A request line stays high, with its data stable, until its acknowledge is seen.
- R9: While a change runs, busy is high and cur_idx keeps its old value. cur_idx takes the new index only after the last acknowledge. Requests and init commands presented while busy are ignored.
- R10: An init command taken while idle runs a forced move to index 0 (the R5 sequence) and then a forced move to index 3 (the R3 sequence), ending at cur_idx 3. It does this even when the block is already at index 0 or index 3.
- R11: A move between two PLL indices runs the full R3 sequence with the word of the new index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle frequency request strobe |
| req_mhz | input | MHZ_W (10) | Requested frequency in MHz |
| init_start | input | 1 | Start the forced low-then-high initialisation |
| busy | output | 1 | Change or initialisation in progress |
| cur_idx | output | 2 | Index of the frequency in use |
| pwr_req | output | 1 | PLL power sequencer request |
| pwr_on | output | 1 | 1 = power up, 0 = power down |
| pwr_ack | input | 1 | Power sequencer acknowledge |
| sel_req | output | 1 | Mux-select commit request |
| sel_id | output | 1 | Which select: 0 = first, 1 = second |
| sel_val | output | SEL_W (4) | Select value to commit |
| sel_ack | input | 1 | Select commit acknowledge |
| word_req | output | 1 | PLL frequency word write request |
| word_data | output | WORD_W (32) | PLL frequency word |
| word_ack | input | 1 | Word write acknowledge |

## Verification
The bench builds the block with its default widths: a 10-bit MHz field, 4-bit select values and a 32-bit word. The 10-bit field lets random stimulus reach many values that are not in the table, next to the four legal ones. The handshake responders answer after a random latency of zero to three cycles. This exercises the holding of each request against both immediate and late acknowledges. The bench also injects stray requests and init commands while a change is under way.

// File: rtl/clkfreq_pkg.sv
package clkfreq_pkg;

    localparam int NUM_FREQ = 4;
    localparam int IDX_W    = $clog2(NUM_FREQ);

    localparam logic [3:0] SEL_CORE_PLL = 4'd8;
    localparam logic [3:0] SEL_BUS_PLL  = 4'd7;
    localparam logic [3:0] SEL_XTAL     = 4'd0;
    localparam logic       SEL_CORE_ID  = 1'b0;
    localparam logic       SEL_BUS_ID   = 1'b1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR_UP,
        ST_CORE_PLL,
        ST_BUS_PLL,
        ST_WORD,
        ST_BUS_XTAL,
        ST_CORE_XTAL,
        ST_PWR_DN
    } step_t;

    typedef enum logic [2:0] {
        IN_OFF,
        IN_LOW_GO,
        IN_LOW_WAIT,
        IN_HIGH_GO,
        IN_HIGH_WAIT
    } init_t;

    typedef struct packed {
        logic             valid;
        logic             force_go;
        logic [IDX_W-1:0] idx;
    } move_t;

    function automatic int unsigned freq_mhz(input int unsigned i);
        case (i)
            0:       return 26;
            1:       return 370;
            2:       return 540;
            default: return 720;
        endcase
    endfunction

    function automatic logic [31:0] pll_word(input logic [IDX_W-1:0] i);
        case (i)
            2'd1:    return 32'h831C7628;
            2'd2:    return 32'h8214C4ED;
            2'd3:    return 32'h821BB13C;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic uses_pll(input logic [IDX_W-1:0] i);
        return i != '0;
    endfunction

endpackage

// File: rtl/clkfreq_lookup.sv
module clkfreq_lookup
    import clkfreq_pkg::*;
#(
    parameter int MHZ_W = 10
) (
    input  logic [MHZ_W-1:0] mhz,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [NUM_FREQ-1:0] match;

    for (genvar g = 0; g < NUM_FREQ; g++) begin : g_cmp
        assign match[g] = (mhz == MHZ_W'(freq_mhz(g)));
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_FREQ; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/clkfreq_init.sv
module clkfreq_init
    import clkfreq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  seq_idle,
    output move_t mv,
    output logic  active
);
    init_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= IN_OFF;
        end else begin
            case (st)
                IN_OFF:       if (start && seq_idle) st <= IN_LOW_GO;
                IN_LOW_GO:    st <= IN_LOW_WAIT;
                IN_LOW_WAIT:  if (seq_idle) st <= IN_HIGH_GO;
                IN_HIGH_GO:   st <= IN_HIGH_WAIT;
                IN_HIGH_WAIT: if (seq_idle) st <= IN_OFF;
                default:      st <= IN_OFF;
            endcase
        end
    end

    always_comb begin
        mv.valid    = (st == IN_LOW_GO) || (st == IN_HIGH_GO);
        mv.force_go = 1'b1;
        mv.idx      = (st == IN_HIGH_GO) ? IDX_W'(NUM_FREQ - 1) : '0;
    end

    assign active = (st != IN_OFF);
endmodule

// File: rtl/clkfreq_seq.sv
module clkfreq_seq
    import clkfreq_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  move_t             mv,
    output logic              idle,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              pwr_req,
    output logic              pwr_on,
    input  logic              pwr_ack,
    output logic              sel_req,
    output logic              sel_id,
    output logic [SEL_W-1:0]  sel_val,
    input  logic              sel_ack,
    output logic              word_req,
    output logic [WORD_W-1:0] word_data,
    input  logic              word_ack
);
    step_t            st;
    logic [IDX_W-1:0] tgt;
    logic             step_ack;

    always_comb begin
        step_ack = 1'b0;
        case (st)
            ST_PWR_UP, ST_PWR_DN:                             step_ack = pwr_ack;
            ST_CORE_PLL, ST_BUS_PLL, ST_BUS_XTAL, ST_CORE_XTAL: step_ack = sel_ack;
            ST_WORD:                                          step_ack = word_ack;
            default:                                          step_ack = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            tgt     <= '0;
            cur_idx <= '0;
        end else if (st == ST_IDLE) begin
            if (mv.valid) begin
                tgt <= mv.idx;
                st  <= uses_pll(mv.idx) ? ST_PWR_UP : ST_BUS_XTAL;
            end
        end else if (step_ack) begin
            case (st)
                ST_PWR_UP:    st <= ST_CORE_PLL;
                ST_CORE_PLL:  st <= ST_BUS_PLL;
                ST_BUS_PLL:   st <= ST_WORD;
                ST_BUS_XTAL:  st <= ST_CORE_XTAL;
                ST_CORE_XTAL: st <= ST_PWR_DN;
                default: begin
                    st      <= ST_IDLE;
                    cur_idx <= tgt;
                end
            endcase
        end
    end

    always_comb begin
        pwr_req   = (st == ST_PWR_UP) || (st == ST_PWR_DN);
        pwr_on    = (st == ST_PWR_UP);
        sel_req   = (st == ST_CORE_PLL) || (st == ST_BUS_PLL) ||
                    (st == ST_BUS_XTAL) || (st == ST_CORE_XTAL);
        sel_id    = (st == ST_BUS_PLL) || (st == ST_BUS_XTAL) ? SEL_BUS_ID : SEL_CORE_ID;
        sel_val   = (st == ST_CORE_PLL) ? SEL_W'(SEL_CORE_PLL) :
                    (st == ST_BUS_PLL)  ? SEL_W'(SEL_BUS_PLL)  : SEL_W'(SEL_XTAL);
        word_req  = (st == ST_WORD);
        word_data = WORD_W'(pll_word(tgt));
    end

    assign idle = (st == ST_IDLE);
endmodule

// File: rtl/clkfreq_switch.sv
module clkfreq_switch
    import clkfreq_pkg::*;
#(
    parameter int MHZ_W  = 10,
    parameter int SEL_W  = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [MHZ_W-1:0]  req_mhz,
    input  logic              init_start,
    output logic              busy,
    output logic [1:0]        cur_idx,
    output logic              pwr_req,
    output logic              pwr_on,
    input  logic              pwr_ack,
    output logic              sel_req,
    output logic              sel_id,
    output logic [SEL_W-1:0]  sel_val,
    input  logic              sel_ack,
    output logic              word_req,
    output logic [WORD_W-1:0] word_data,
    input  logic              word_ack
);
    logic             hit;
    logic [IDX_W-1:0] ext_idx;
    logic             seq_idle;
    logic             init_active;
    move_t            init_mv;
    move_t            mv;
    logic [IDX_W-1:0] idx_q;

    clkfreq_lookup #(.MHZ_W(MHZ_W)) u_lookup (
        .mhz (req_mhz),
        .hit (hit),
        .idx (ext_idx)
    );

    clkfreq_init u_init (
        .clk      (clk),
        .rst      (rst),
        .start    (init_start),
        .seq_idle (seq_idle),
        .mv       (init_mv),
        .active   (init_active)
    );

    always_comb begin
        if (init_active) begin
            mv = init_mv;
        end else begin
            mv.force_go = 1'b0;
            mv.idx      = ext_idx;
            mv.valid    = req_valid && hit && (ext_idx != idx_q) &&
                          !init_start && seq_idle;
        end
    end

    clkfreq_seq #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mv        (mv),
        .idle      (seq_idle),
        .cur_idx   (idx_q),
        .pwr_req   (pwr_req),
        .pwr_on    (pwr_on),
        .pwr_ack   (pwr_ack),
        .sel_req   (sel_req),
        .sel_id    (sel_id),
        .sel_val   (sel_val),
        .sel_ack   (sel_ack),
        .word_req  (word_req),
        .word_data (word_data),
        .word_ack  (word_ack)
    );

    assign cur_idx = idx_q;
    assign busy    = !seq_idle || init_active;
endmodule

// File: rtl/clkfreq_switch_chk.sv
module clkfreq_switch_chk #(
    parameter int SEL_W  = 4,
    parameter int WORD_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [1:0]       cur_idx,
    input logic             pwr_req,
    input logic             pwr_on,
    input logic             pwr_ack,
    input logic             sel_req,
    input logic             sel_id,
    input logic [SEL_W-1:0] sel_val,
    input logic             sel_ack,
    input logic             word_req
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cur_idx == 2'd0 && !busy && !pwr_req && !sel_req && !word_req));

    // R8
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pwr_req, sel_req, word_req}));

    // R8
    pwr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_req && !pwr_ack) |=> (pwr_req && $stable(pwr_on)));

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_req && !sel_ack) |=> (sel_req && $stable(sel_id) && $stable(sel_val)));

    // R9
    idx_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_idx) |-> $past(busy));

    // R3
    word_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(word_req) |-> ($past(sel_req) && $past(sel_id) == 1'b1));

    // R5
    pwr_dn_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwr_req) && !pwr_on) |-> ($past(sel_req) && $past(sel_val) == '0));
endmodule

bind clkfreq_switch clkfreq_switch_chk #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .cur_idx (cur_idx),
    .pwr_req (pwr_req),
    .pwr_on  (pwr_on),
    .pwr_ack (pwr_ack),
    .sel_req (sel_req),
    .sel_id  (sel_id),
    .sel_val (sel_val),
    .sel_ack (sel_ack),
    .word_req(word_req)
);

// File: tb/clkfreq_switch_test.sv
module clkfreq_switch_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [9:0]  req_mhz = '0;
    logic        init_start = 1'b0;
    logic        busy;
    logic [1:0]  cur_idx;
    logic        pwr_req, pwr_on, sel_req, sel_id, word_req;
    logic        pwr_ack, sel_ack, word_ack;
    logic [3:0]  sel_val;
    logic [31:0] word_data;

    int total = 0;
    int bad = 0;
    int model_idx = 0;
    int seed_val;
    bit timeout = 1'b0;

    always #2 clk = ~clk;

    clkfreq_switch uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mhz(req_mhz),
        .init_start(init_start), .busy(busy), .cur_idx(cur_idx),
        .pwr_req(pwr_req), .pwr_on(pwr_on), .pwr_ack(pwr_ack),
        .sel_req(sel_req), .sel_id(sel_id), .sel_val(sel_val), .sel_ack(sel_ack),
        .word_req(word_req), .word_data(word_data), .word_ack(word_ack)
    );

    // handshake responders with random latency 0..3
    int pl = 0, pc = 0, sl = 0, sc = 0, wl = 0, wc = 0;
    always @(posedge clk) begin
        if (rst) begin
            pwr_ack <= 1'b0; sel_ack <= 1'b0; word_ack <= 1'b0;
            pc <= 0; sc <= 0; wc <= 0;
        end else begin
            if (pwr_ack) pwr_ack <= 1'b0;
            else if (pwr_req) begin
                if (pc >= pl) begin pwr_ack <= 1'b1; pc <= 0; pl <= int'($urandom % 4); end
                else pc <= pc + 1;
            end
            if (sel_ack) sel_ack <= 1'b0;
            else if (sel_req) begin
                if (sc >= sl) begin sel_ack <= 1'b1; sc <= 0; sl <= int'($urandom % 4); end
                else sc <= sc + 1;
            end
            if (word_ack) word_ack <= 1'b0;
            else if (word_req) begin
                if (wc >= wl) begin word_ack <= 1'b1; wc <= 0; wl <= int'($urandom % 4); end
                else wc <= wc + 1;
            end
        end
    end

    // event log: {kind[1:0], id, val[3:0], data[31:0]}
    logic [38:0] act_log [0:1023];
    int act_n = 0;
    always @(posedge clk) begin
        if (!rst) begin
            if (pwr_req && pwr_ack) begin
                act_log[act_n % 1024] <= {2'd0, 1'b0, 4'd0, 31'd0, pwr_on};
                act_n <= act_n + 1;
            end else if (sel_req && sel_ack) begin
                act_log[act_n % 1024] <= {2'd1, sel_id, sel_val, 32'd0};
                act_n <= act_n + 1;
            end else if (word_req && word_ack) begin
                act_log[act_n % 1024] <= {2'd2, 1'b0, 4'd0, word_data};
                act_n <= act_n + 1;
            end
        end
    end

    logic [38:0] exp_log [0:15];
    int exp_n;

    function automatic int idx_of(input int mhz);
        case (mhz)
            26:      return 0;
            370:     return 1;
            540:     return 2;
            720:     return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] word_of(input int i);
        case (i)
            1:       return 32'h831C7628;
            2:       return 32'h8214C4ED;
            default: return 32'h821BB13C;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic add_move(input int t);
        if (t == 0) begin
            exp_log[exp_n] = {2'd1, 1'b1, 4'd0, 32'd0}; exp_n++;
            exp_log[exp_n] = {2'd1, 1'b0, 4'd0, 32'd0}; exp_n++;
            exp_log[exp_n] = {2'd0, 1'b0, 4'd0, 32'd0}; exp_n++;
        end else begin
            exp_log[exp_n] = {2'd0, 1'b0, 4'd0, 32'd1}; exp_n++;
            exp_log[exp_n] = {2'd1, 1'b0, 4'd8, 32'd0}; exp_n++;
            exp_log[exp_n] = {2'd1, 1'b1, 4'd7, 32'd0}; exp_n++;
            exp_log[exp_n] = {2'd2, 1'b0, 4'd0, word_of(t)}; exp_n++;
        end
    endtask

    task automatic wait_idle;
        int n = 0;
        while (busy && n < 200) begin @(negedge clk); n++; end
        if (busy) timeout = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic compare(input int base, input string req);
        check(act_n - base == exp_n, req, act_n - base, exp_n);
        for (int i = 0; i < exp_n && i < act_n - base; i++)
            check(act_log[(base + i) % 1024] == exp_log[i], req,
                  act_log[(base + i) % 1024], exp_log[i]);
        check(cur_idx == 2'(model_idx), req, cur_idx, model_idx);
        check(!busy, req, busy, 0);
    endtask

    task automatic do_req(input int mhz, input bit stray, input string req);
        int base = act_n;
        int t = idx_of(mhz);
        int old = model_idx;
        exp_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_mhz = 10'(mhz);
        @(negedge clk);
        req_valid = 1'b0;
        if (t < 0 || t == model_idx) begin
            check(!busy, t < 0 ? "R7" : "R6", busy, 0);
        end else begin
            check(busy, "R9", busy, 1);
            check(cur_idx == 2'(old), "R9", cur_idx, old);
            if (stray) begin
                req_valid = 1'b1; req_mhz = 10'(t == 3 ? 26 : 720); init_start = 1'b1;
                @(negedge clk);
                req_valid = 1'b0; init_start = 1'b0;
                check(cur_idx == 2'(old), "R9", cur_idx, old);
            end
            add_move(t);
            model_idx = t;
        end
        wait_idle();
        compare(base, req);
    endtask

    task automatic do_init(input string req);
        int base = act_n;
        exp_n = 0;
        @(negedge clk);
        init_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
        check(busy, "R10", busy, 1);
        add_move(0);
        add_move(3);
        model_idx = 3;
        wait_idle();
        compare(base, req);
    endtask

    initial begin
        seed_val = int'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cur_idx == 2'd0, "R1", cur_idx, 0);
        check(!busy && !pwr_req && !sel_req && !word_req, "R1",
              {busy, pwr_req, sel_req, word_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cur_idx == 2'd0 && !busy, "R1", cur_idx, 0);

        do_req(26, 0, "R6");
        do_req(100, 0, "R7");
        do_req(540, 0, "R3");
        do_req(720, 0, "R11");
        do_req(370, 0, "R4");
        do_req(370, 0, "R6");
        do_req(26, 0, "R5");
        do_req(540, 1, "R9");
        do_req(26, 1, "R9");
        do_init("R10");
        do_init("R10");
        do_req(26, 0, "R5");
        do_init("R10");
        do_req(1023, 0, "R7");
        do_req(0, 0, "R7");

        for (int i = 0; i < 60; i++) begin
            int pick = int'($urandom % 6);
            int mhz;
            case (pick)
                0: mhz = 26;
                1: mhz = 370;
                2: mhz = 540;
                3: mhz = 720;
                default: mhz = int'($urandom % 1024);
            endcase
            if ($urandom % 10 == 0) do_init("R10");
            else do_req(mhz, bit'($urandom % 2), "R2");
        end

        if (timeout) check(1'b0, "watchdog", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule